// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits beside the ECC checker of a DRAM controller. The checker sends a one-cycle pulse whenever an access shows a correctable or an uncorrectable error, together with the failing physical address, an 8-bit syndrome and the channel index. The logger keeps sticky status flags, one for each error type, and a single set of details: a 4 KiB block address, the syndrome and the channel. A correctable error is recorded only into an empty log. An uncorrectable error takes over the details unless an uncorrectable error is already recorded.

Software reads the log and clears it through a small synchronous register port. Each status flag is cleared by writing 1 to it. A command register holds one enable per error type. An enabled error that is newly recorded raises a one-cycle system-error pulse.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every readable register returns 0 and `serr_o` is low.
- R2: A correctable pulse while both status flags are clear sets status bit 0. It records the syndrome (offset 0x04, bits 7:0), the channel (offset 0x05, bit 0) and the address bits 31:12 (offset 0x00). Address bits 11:0 read as 0, and so do address bits at or above ADDR_W.
- R3: A correctable pulse while either status flag is set leaves the address, syndrome and channel unchanged.
- R4: An uncorrectable pulse while status bit 7 is clear sets bit 7 and replaces the recorded details, even when a correctable error is already recorded. Status then reads 0x0081.
- R5: An uncorrectable pulse while status bit 7 is already set leaves the details unchanged.
- R6: When correctable and uncorrectable pulses arrive in the same cycle and the log is empty, the uncorrectable details are recorded and both flags are set.
- R7: A write to offset 0x08 clears status bit 0 when wdata bit 0 is 1, and clears bit 7 when wdata bit 7 is 1. All other wdata bits have no effect.
- R8: If a clearing write and a new error of the same type fall in the same cycle, that type's flag stays set.
- R9: Once both flags have been cleared, the next error of either type is recorded as a fresh entry.
- R10: The command register at offset 0x0A keeps wdata bit 8 (enable on uncorrectable) and bit 7 (enable on correctable). Its other bits read 0.
- R11: `serr_o` is high for exactly one cycle, one cycle after a pulse whose type flag was clear and whose enable bit was set. It is low at all other times.
- R12: A read (`reg_en`=1, `reg_we`=0) returns its data on `reg_rdata` one cycle later. The status word is at 0x08. Any offset not listed above reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_pulse | input | 1 | Correctable error seen this cycle |
| ue_pulse | input | 1 | Uncorrectable error seen this cycle |
| err_addr | input | ADDR_W | Failing physical address |
| err_syn | input | SYN_W | ECC syndrome of the failing access |
| err_chan | input | 1 | Channel of the failing access |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read |
| serr_o | output | 1 | System-error pulse |

## Verification
The bench builds the block with ADDR_W=30 and SYN_W=8. With ADDR_W=30, random addresses that fill the whole 32-bit stimulus word show that bits 31:30 and the low twelve bits of the address register read as zero. The full 8-bit syndrome checks that syndrome bits travel unchanged into the register byte. The same seeded random mix of pulses, clearing writes and enable changes then drives every combination of recorded state and new event, including errors that land in the same cycle as a clear.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam logic [7:0] OFS_ADDR   = 8'h00;
  localparam logic [7:0] OFS_SYN    = 8'h04;
  localparam logic [7:0] OFS_CHAN   = 8'h05;
  localparam logic [7:0] OFS_STATUS = 8'h08;
  localparam logic [7:0] OFS_CMD    = 8'h0A;

  localparam int STS_CE_BIT = 0;
  localparam int STS_UE_BIT = 7;
  localparam int CMD_CE_BIT = 7;
  localparam int CMD_UE_BIT = 8;

  localparam int BLK_LSB = 12;

  function automatic logic [15:0] pack_status(input logic ce, input logic ue);
    logic [15:0] w;
    w = '0;
    w[STS_CE_BIT] = ce;
    w[STS_UE_BIT] = ue;
    return w;
  endfunction

  function automatic logic [15:0] pack_cmd(input logic en_ce, input logic en_ue);
    logic [15:0] w;
    w = '0;
    w[CMD_CE_BIT] = en_ce;
    w[CMD_UE_BIT] = en_ue;
    return w;
  endfunction

  // A sticky flag after one cycle: a new event always beats a clear.
  function automatic logic next_flag(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  localparam int BLK_W = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_pulse,
  input  logic              ue_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  input  logic              clr_ce,
  input  logic              clr_ue,
  output logic              ce_sts_q,
  output logic              ue_sts_q,
  output logic              ce_new,
  output logic              ue_new,
  output logic [BLK_W-1:0]  blk_q,
  output logic [SYN_W-1:0]  syn_q,
  output logic              chan_q
);

  logic take_ue;
  logic take_ce;
  logic load_details;
  logic [BLK_LSB-1:0] unused_low_addr;

  assign unused_low_addr = err_addr[BLK_LSB-1:0];

  assign ce_new = ce_pulse & ~ce_sts_q;
  assign ue_new = ue_pulse & ~ue_sts_q;

  // Uncorrectable takes over unless one is already held; correctable only fills an empty log.
  assign take_ue      = ue_new;
  assign take_ce      = ce_pulse & ~ue_pulse & ~ce_sts_q & ~ue_sts_q;
  assign load_details = take_ue | take_ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_sts_q <= 1'b0;
      ue_sts_q <= 1'b0;
    end else begin
      ce_sts_q <= next_flag(ce_sts_q, clr_ce, ce_pulse);
      ue_sts_q <= next_flag(ue_sts_q, clr_ue, ue_pulse);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (load_details) begin
      blk_q  <= err_addr[ADDR_W-1:BLK_LSB];
      syn_q  <= err_syn;
      chan_q <= err_chan;
    end
  end

  // R3
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pulse && !ue_pulse && (ce_sts_q || ue_sts_q)) |=> ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));

  // R4
  ue_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse && !ue_sts_q) |=> (syn_q == $past(err_syn) && chan_q == $past(err_chan)));

  // R5
  ue_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse && ue_sts_q) |=> $stable(syn_q));

  // R8
  ue_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_pulse |=> ue_sts_q);

  // R8
  ce_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse |=> ce_sts_q);

  // R7
  ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && !ce_pulse) |=> !ce_sts_q);

  // R7
  ue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ue && !ue_pulse) |=> !ue_sts_q);

endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  localparam int BLK_W = ADDR_W - BLK_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ce_sts,
  input  logic             ue_sts,
  input  logic [BLK_W-1:0] blk,
  input  logic [SYN_W-1:0] syn,
  input  logic             chan,
  output logic             clr_ce,
  output logic             clr_ue,
  output logic             en_ce,
  output logic             en_ue
);

  logic        wr_status;
  logic        wr_cmd;
  logic        rd_req;
  logic [31:0] addr_word;
  logic [31:0] syn_word;
  logic [31:0] rd_mux;
  logic [31:0] rdata_q;
  logic [22:0] unused_wdata;

  assign unused_wdata = {reg_wdata[31:9], reg_wdata[6:1]};

  assign wr_status = reg_en & reg_we & (reg_addr == OFS_STATUS);
  assign wr_cmd    = reg_en & reg_we & (reg_addr == OFS_CMD);
  assign rd_req    = reg_en & ~reg_we;

  assign clr_ce = wr_status & reg_wdata[STS_CE_BIT];
  assign clr_ue = wr_status & reg_wdata[STS_UE_BIT];

  generate
    if (ADDR_W < 32) begin : g_addr_pad
      assign addr_word = {{(32-ADDR_W){1'b0}}, blk, {BLK_LSB{1'b0}}};
    end else begin : g_addr_full
      assign addr_word = {blk, {BLK_LSB{1'b0}}};
    end
    if (SYN_W < 32) begin : g_syn_pad
      assign syn_word = {{(32-SYN_W){1'b0}}, syn};
    end else begin : g_syn_full
      assign syn_word = syn[31:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_ce <= 1'b0;
      en_ue <= 1'b0;
    end else if (wr_cmd) begin
      en_ce <= reg_wdata[CMD_CE_BIT];
      en_ue <= reg_wdata[CMD_UE_BIT];
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_ADDR:   rd_mux = addr_word;
      OFS_SYN:    rd_mux = syn_word;
      OFS_CHAN:   rd_mux = {31'd0, chan};
      OFS_STATUS: rd_mux = {16'd0, pack_status(ce_sts, ue_sts)};
      OFS_CMD:    rd_mux = {16'd0, pack_cmd(en_ce, en_ue)};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  // R10
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (en_ue == $past(reg_wdata[CMD_UE_BIT])));

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && reg_addr == OFS_CHAN) |=> (reg_rdata[31:1] == 31'd0));

endmodule

// File: rtl/ecc_log_alert.sv
module ecc_log_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_new,
  input  logic ue_new,
  input  logic en_ce,
  input  logic en_ue,
  output logic serr_o
);

  logic fire;

  assign fire = (ce_new & en_ce) | (ue_new & en_ue);

  always_ff @(posedge clk) begin
    if (!rst_n) serr_o <= 1'b0;
    else        serr_o <= fire;
  end

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_pulse,
  input  logic              ue_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              serr_o
);

  localparam int BLK_W = ADDR_W - BLK_LSB;

  logic             ce_sts;
  logic             ue_sts;
  logic             ce_new;
  logic             ue_new;
  logic [BLK_W-1:0] blk;
  logic [SYN_W-1:0] syn;
  logic             chan;
  logic             clr_ce;
  logic             clr_ue;
  logic             en_ce;
  logic             en_ue;

  ecc_log_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_pulse (ce_pulse),
    .ue_pulse (ue_pulse),
    .err_addr (err_addr),
    .err_syn  (err_syn),
    .err_chan (err_chan),
    .clr_ce   (clr_ce),
    .clr_ue   (clr_ue),
    .ce_sts_q (ce_sts),
    .ue_sts_q (ue_sts),
    .ce_new   (ce_new),
    .ue_new   (ue_new),
    .blk_q    (blk),
    .syn_q    (syn),
    .chan_q   (chan)
  );

  ecc_log_regif #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ce_sts    (ce_sts),
    .ue_sts    (ue_sts),
    .blk       (blk),
    .syn       (syn),
    .chan      (chan),
    .clr_ce    (clr_ce),
    .clr_ue    (clr_ue),
    .en_ce     (en_ce),
    .en_ue     (en_ue)
  );

  ecc_log_alert u_alert (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_new (ce_new),
    .ue_new (ue_new),
    .en_ce  (en_ce),
    .en_ue  (en_ue),
    .serr_o (serr_o)
  );

  // R11
  serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> $past(ce_pulse || ue_pulse));

  // R6
  dual_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pulse && ue_pulse) |=> (ce_sts && ue_sts));

endmodule

// File: tb/ecc_err_logger_bench.sv
`timescale 1ns/1ps
module ecc_err_logger_bench;

  localparam int AW = 30;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_pulse = 1'b0;
  logic          ue_pulse = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic [SW-1:0] err_syn = '0;
  logic          err_chan = 1'b0;
  logic          reg_en = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          serr_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the logger
  logic        m_ce = 0, m_ue = 0, m_en_ce = 0, m_en_ue = 0, m_ch = 0;
  logic [31:0] m_addr = 0;
  logic [7:0]  m_syn = 0;

  always #2 clk = ~clk;

  ecc_err_logger #(.ADDR_W(AW), .SYN_W(SW)) u_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
    .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr_o(serr_o)
  );

  function automatic logic [31:0] blk_of(input logic [31:0] a);
    return a & ((32'd1 << AW) - 32'd1) & 32'hFFFF_F000;
  endfunction

  function automatic logic [31:0] status_word(input logic ce, input logic ue);
    return {24'd0, ue, 6'd0, ce};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; checks serr in the following cycle.
  task automatic step(input logic ce, input logic ue, input logic [31:0] a,
                      input logic [7:0] s, input logic c, input logic wr,
                      input logic [7:0] wa, input logic [31:0] wd, input string req);
    logic exp_serr;
    logic o_ce, o_ue;
    ce_pulse = ce; ue_pulse = ue; err_addr = a[AW-1:0]; err_syn = s; err_chan = c;
    reg_en = wr; reg_we = wr; reg_addr = wa; reg_wdata = wd;
    o_ce = m_ce; o_ue = m_ue;
    exp_serr = (ce & ~o_ce & m_en_ce) | (ue & ~o_ue & m_en_ue);
    if (ue && !o_ue) begin
      m_addr = blk_of(a); m_syn = s; m_ch = c;
    end else if (ce && !ue && !o_ce && !o_ue) begin
      m_addr = blk_of(a); m_syn = s; m_ch = c;
    end
    if (wr && wa == 8'h08) begin
      m_ce = (o_ce & ~wd[0]) | ce;
      m_ue = (o_ue & ~wd[7]) | ue;
    end else begin
      m_ce = o_ce | ce;
      m_ue = o_ue | ue;
    end
    if (wr && wa == 8'h0A) begin
      m_en_ce = wd[7]; m_en_ue = wd[8];
    end
    @(negedge clk);
    ce_pulse = 0; ue_pulse = 0; reg_en = 0; reg_we = 0;
    chk({31'd0, serr_o}, {31'd0, exp_serr}, {req, " R11 serr"});
  endtask

  task automatic rd(input logic [7:0] ofs, input logic [31:0] exp, input string req);
    reg_en = 1; reg_we = 0; reg_addr = ofs;
    @(negedge clk);
    reg_en = 0;
    chk(reg_rdata, exp, req);
    chk({31'd0, serr_o}, 32'd0, {req, " R11 quiet"});
  endtask

  task automatic rd_all(input string req);
    rd(8'h00, m_addr, {req, " R12 addr"});
    rd(8'h04, {24'd0, m_syn}, {req, " R12 syn"});
    rd(8'h05, {31'd0, m_ch}, {req, " R12 chan"});
    rd(8'h08, status_word(m_ce, m_ue), {req, " R12 status"});
    rd(8'h0A, {23'd0, m_en_ue, m_en_ce, 7'd0}, {req, " R10 cmd"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({31'd0, serr_o}, 32'd0, "R1 serr");
    rd_all("R1");
    rd(8'h0C, 32'd0, "R12 unmapped");
    // R10 only enable bits kept
    step(0, 0, 0, 0, 0, 1, 8'h0A, 32'hFFFF_FFFF, "R10 wr");
    rd_all("R10");
    // R2 first correctable
    step(1, 0, 32'hFFFF_F123, 8'hA5, 1, 0, 0, 0, "R2");
    rd_all("R2");
    // R3 second correctable ignored
    step(1, 0, 32'h1234_5678, 8'h3C, 0, 0, 0, 0, "R3");
    rd_all("R3");
    // R4 uncorrectable takes over
    step(0, 1, 32'h0ABC_D000, 8'h5A, 0, 0, 0, 0, "R4");
    rd_all("R4");
    // R5 second uncorrectable ignored
    step(0, 1, 32'h2222_2000, 8'h11, 1, 0, 0, 0, "R5");
    rd_all("R5");
    // R7 other bits have no effect, then per-bit clears
    step(0, 0, 0, 0, 0, 1, 8'h08, 32'hFFFF_FF7E, "R7 noop");
    rd_all("R7 noop");
    step(0, 0, 0, 0, 0, 1, 8'h08, 32'h0000_0001, "R7 ce");
    rd_all("R7 ce");
    step(0, 0, 0, 0, 0, 1, 8'h08, 32'h0000_0080, "R7 ue");
    rd_all("R7 ue");
    // R9 fresh entry after clears
    step(1, 0, 32'h0003_3000, 8'h77, 0, 0, 0, 0, "R9");
    rd_all("R9");
    // R8 clear and error in same cycle
    step(1, 0, 32'h0004_4000, 8'h01, 1, 1, 8'h08, 32'h0000_0081, "R8");
    rd_all("R8");
    step(0, 0, 0, 0, 0, 1, 8'h08, 32'h0000_0081, "R8 clr");
    step(0, 0, 0, 0, 0, 1, 8'h0A, 32'h0000_0000, "R10 off");
    // R6 both types together, enables off
    step(1, 1, 32'h0055_5000, 8'hEE, 1, 0, 0, 0, "R6");
    rd_all("R6");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [31:0] wd;
      logic [7:0]  wa;
      logic        wr;
      r  = $urandom;
      wr = (r[3:0] < 4);
      wa = r[4] ? 8'h08 : 8'h0A;
      wd = $urandom;
      step(r[8] & r[9], r[10] & r[11] & r[12], $urandom, r[23:16], r[24],
           wr, wa, wd, "R2 R3 R4 R8 random");
      if (r[31:29] == 0) rd_all("R3 R4 R5 random");
    end
    rd_all("final");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule